// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic and logic unit of a small accumulator-style datapath. The first operand is the current accumulator value. The second operand is the value on the shared data bus. A 4-bit select code picks one of thirteen operations: arithmetic (add, subtract, increment), bitwise logic, one-bit shifts and a pass-through of the accumulator. The 32-bit result is available combinationally, so the surrounding datapath can capture it in its own result register.

Three condition flags (zero, sign and carry) are held in registers inside the block. They change only on a clock edge where the flag-update enable is high and the selected operation is an add, a subtract or an increment. At any other time they keep the values left by the last such arithmetic operation. Every other operation, the unused select codes and a low enable leave the flags alone. An asynchronous active-low reset clears all three flags.

Top module: `acc_alu`

## Requirements
- R1: Select code 0000 gives `acc_a + bus_b` modulo 2^32 on `result` in the same cycle.
- R2: Select code 0001 gives `acc_a - bus_b` modulo 2^32 on `result`.
- R3: Select codes 0010, 0011, 0100 and 0101 give the bitwise AND, OR, XOR and NOR of `acc_a` and `bus_b`.
- R4: Select code 0110 gives the bitwise inverse of `acc_a`. Code 1011 gives `acc_a + 1`. Code 1100 gives `acc_a` unchanged. In all three cases `bus_b` has no effect.
- R5: Select codes 0111 (logical) and 1000 (arithmetic) both give `acc_a` shifted left by one bit, with zero in bit 0.
- R6: Select code 1001 gives `acc_a` shifted right by one bit with zero in bit 31. Code 1010 does the same shift but copies the old bit 31 into bit 31.
- R7: Select codes 1101, 1110 and 1111 give a `result` of zero and do not change the flags.
- R8: On a rising clock edge where `flag_en` is high and the code is 0000, 0001 or 1011, `flag_z` becomes 1 exactly when `result` was zero, and `flag_s` takes bit 31 of `result`.
- R9: On such an update, `flag_cy` takes the carry out of bit 31. For add, that is the carry of A+B. For subtract, it is the carry of A + ~B + 1, so 1 means no borrow (A ≥ B unsigned). For increment, it is the carry of A+1.
- R10: On a rising edge where `flag_en` is low, or where the code is not 0000, 0001 or 1011, all three flags keep their values.
- R11: While `rst_n` is low, all three flags are 0. Reset takes effect at once, with no wait for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag registers |
| rst_n | input | 1 | Asynchronous active-low reset, clears the flags |
| flag_en | input | 1 | Allows the flags to update on arithmetic operations |
| op_sel | input | 4 | Operation select code |
| acc_a | input | 32 | First operand, from the accumulator |
| bus_b | input | 32 | Second operand, from the data bus |
| result | output | 32 | Combinational operation result |
| flag_z | output | 1 | Registered zero flag |
| flag_s | output | 1 | Registered sign flag |
| flag_cy | output | 1 | Registered carry flag |

## Verification
The bench targets several corner cases:
- The carry edge cases of the shared adder: an all-ones plus one, a subtract that borrows, and an increment that wraps. A design that used a raw borrow, or left out the increment carry-in, would show the wrong carry flag.
- The two right shifts, with bit 31 set in the operand. A design that swapped the zero fill and the sign fill would put the wrong value in bit 31.
- The unused select codes, driven with nonzero operands while the enable is high. A design that let these codes through would return a stray result or disturb the flags.
- Flag retention under a low enable and under logic operations, checked after setting the flags to a nonzero state. A design that loaded the flags on every edge would lose that state.
- The reset, asserted between clock edges. This shows whether the flag reset acts at once or only at the next edge.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'b0000,
        OP_SUB  = 4'b0001,
        OP_AND  = 4'b0010,
        OP_OR   = 4'b0011,
        OP_XOR  = 4'b0100,
        OP_NOR  = 4'b0101,
        OP_NOTA = 4'b0110,
        OP_SHLL = 4'b0111,
        OP_SHLA = 4'b1000,
        OP_SHRL = 4'b1001,
        OP_SHRA = 4'b1010,
        OP_INC  = 4'b1011,
        OP_PASS = 4'b1100
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic s;
        logic cy;
    } alu_flags_t;

    function automatic logic op_is_arith(input logic [OP_W-1:0] code);
        return (code == OP_ADD) || (code == OP_SUB) || (code == OP_INC);
    endfunction

endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder
    import acc_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    output logic [W-1:0]    sum,
    output logic            carry
);
    logic [W-1:0] rhs;
    logic         cin;
    logic [W:0]   full;

    always_comb begin
        rhs = '0;
        cin = 1'b0;
        unique case (op)
            OP_ADD:  begin rhs = b;  cin = 1'b0; end
            OP_SUB:  begin rhs = ~b; cin = 1'b1; end
            OP_INC:  begin rhs = '0; cin = 1'b1; end
            default: begin rhs = '0; cin = 1'b0; end
        endcase
    end

    assign full  = {1'b0, a} + {1'b0, rhs} + {{W{1'b0}}, cin};
    assign sum   = full[W-1:0];
    assign carry = full[W];

endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
    import acc_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    output logic [W-1:0]    y
);
    localparam int MSB = W - 1;

    always_comb begin
        y = '0;
        unique case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_NOR:  y = ~(a | b);
            OP_NOTA: y = ~a;
            OP_SHLL,
            OP_SHLA: y = {a[MSB-1:0], 1'b0};
            OP_SHRL: y = {1'b0, a[MSB:1]};
            OP_SHRA: y = {a[MSB], a[MSB:1]};
            OP_PASS: y = a;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/acc_alu_flagreg.sv
module acc_alu_flagreg
    import acc_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] res,
    input  logic         carry,
    output alu_flags_t   flags
);
    alu_flags_t next_flags;

    always_comb begin
        next_flags    = flags;
        if (load) begin
            next_flags.z  = (res == '0);
            next_flags.s  = res[W-1];
            next_flags.cy = carry;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= next_flags;
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flag_en,
    input  logic [3:0]   op_sel,
    input  logic [W-1:0] acc_a,
    input  logic [W-1:0] bus_b,
    output logic [W-1:0] result,
    output logic         flag_z,
    output logic         flag_s,
    output logic         flag_cy
);
    logic [W-1:0] add_y;
    logic         add_cy;
    logic [W-1:0] bit_y;
    logic         arith;
    alu_flags_t   flags_q;

    assign arith = op_is_arith(op_sel);

    acc_alu_adder #(.W(W)) i_adder (
        .op    (op_sel),
        .a     (acc_a),
        .b     (bus_b),
        .sum   (add_y),
        .carry (add_cy)
    );

    acc_alu_bitops #(.W(W)) i_bitops (
        .op (op_sel),
        .a  (acc_a),
        .b  (bus_b),
        .y  (bit_y)
    );

    assign result = arith ? add_y : bit_y;

    acc_alu_flagreg #(.W(W)) i_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (flag_en && arith),
        .res   (add_y),
        .carry (add_cy),
        .flags (flags_q)
    );

    assign flag_z  = flags_q.z;
    assign flag_s  = flags_q.s;
    assign flag_cy = flags_q.cy;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         flag_en,
    input logic [3:0]   op_sel,
    input logic [W-1:0] acc_a,
    input logic [W-1:0] bus_b,
    input logic [W-1:0] result,
    input logic         flag_z,
    input logic         flag_s,
    input logic         flag_cy
);
    logic upd;
    assign upd = flag_en && (op_sel == 4'd0 || op_sel == 4'd1 || op_sel == 4'd11);

    // R10
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable({flag_z, flag_s, flag_cy}));

    // R8
    flag_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (flag_z == ($past(result) == '0)));

    // R8
    flag_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (flag_s == $past(result[W-1])));

    // R9
    sub_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && op_sel == 4'd1) |=> (flag_cy == ($past(acc_a) >= $past(bus_b))));

    // R7
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel >= 4'd13) |-> (result == '0));

    // R6
    sra_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 4'd10) |-> (result == {acc_a[W-1], acc_a[W-1:1]}));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (!flag_z && !flag_s && !flag_cy));

endmodule

bind acc_alu acc_alu_chk #(.W(W)) i_chk (.*);

// File: tb/test_acc_alu.sv
`timescale 1ns/1ps
module test_acc_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flag_en = 1'b0;
    logic [3:0]  op_sel = 4'd0;
    logic [31:0] acc_a = '0;
    logic [31:0] bus_b = '0;
    logic [31:0] result;
    logic        flag_z, flag_s, flag_cy;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic ez = 0, es = 0, ecy = 0;

    always #4 clk = ~clk;

    acc_alu i_acc_alu (
        .clk(clk), .rst_n(rst_n), .flag_en(flag_en), .op_sel(op_sel),
        .acc_a(acc_a), .bus_b(bus_b), .result(result),
        .flag_z(flag_z), .flag_s(flag_s), .flag_cy(flag_cy)
    );

    // op(4) a(32) b(32) expected result(32)
    localparam int NV = 19;
    localparam logic [99:0] VEC [NV] = '{
        {4'h0, 32'h0000_0005, 32'h0000_0003, 32'h0000_0008},
        {4'h0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000},
        {4'h1, 32'h0000_0010, 32'h0000_0003, 32'h0000_000D},
        {4'h1, 32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFE},
        {4'h2, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'hF000_F000},
        {4'h3, 32'hF0F0_F0F0, 32'h0F00_0F00, 32'hFFF0_FFF0},
        {4'h4, 32'hAAAA_AAAA, 32'hFFFF_0000, 32'h5555_AAAA},
        {4'h5, 32'hF0F0_F0F0, 32'h0F0F_0000, 32'h0000_0F0F},
        {4'h6, 32'h1234_5678, 32'hFFFF_FFFF, 32'hEDCB_A987},
        {4'h7, 32'h8000_0001, 32'h0000_0000, 32'h0000_0002},
        {4'h8, 32'hC000_0003, 32'h0000_0000, 32'h8000_0006},
        {4'h9, 32'h8000_0003, 32'h0000_0000, 32'h4000_0001},
        {4'hA, 32'h8000_0003, 32'h0000_0000, 32'hC000_0001},
        {4'hA, 32'h4000_0002, 32'h0000_0000, 32'h2000_0001},
        {4'hB, 32'h0000_00FF, 32'h1234_0000, 32'h0000_0100},
        {4'hC, 32'h1357_9BDF, 32'hFFFF_FFFF, 32'h1357_9BDF},
        {4'hD, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000},
        {4'hE, 32'h1234_5678, 32'h8765_4321, 32'h0000_0000},
        {4'hF, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000}
    };

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'h0: return "R1";
            4'h1: return "R2";
            4'h2, 4'h3, 4'h4, 4'h5: return "R3";
            4'h6, 4'hB, 4'hC: return "R4";
            4'h7, 4'h8: return "R5";
            4'h9, 4'hA: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_flags(input string req);
        check(req, {29'd0, flag_z, flag_s, flag_cy}, {29'd0, ez, es, ecy});
    endtask

    // apply one operation, check result before the edge and flags after it
    task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic en, input logic [31:0] exp_res);
        logic [32:0] t;
        @(negedge clk);
        op_sel = op; acc_a = a; bus_b = b; flag_en = en;
        #1;
        check(req_of(op), result, exp_res);
        t = '0;
        if (op == 4'h0)      t = {1'b0, a} + {1'b0, b};
        else if (op == 4'h1) t = {1'b0, a} + {1'b0, ~b} + 33'd1;
        else if (op == 4'hB) t = {1'b0, a} + 33'd1;
        if (en && (op == 4'h0 || op == 4'h1 || op == 4'hB)) begin
            ez = (t[31:0] == 32'd0); es = t[31]; ecy = t[32];
        end
        @(posedge clk); #1;
        // R8 R9 R10: flags follow the last enabled arithmetic operation only
        check_flags((op == 4'h0 || op == 4'h1 || op == 4'hB) && en ? "R9" : "R10");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        check_flags("R11");
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NV; i++)
            apply(VEC[i][99:96], VEC[i][95:64], VEC[i][63:32], 1'b1, VEC[i][31:0]);

        // increment wrap: z=1 s=0 cy=1 (R9)
        apply(4'hB, 32'hFFFF_FFFF, 32'h0, 1'b1, 32'h0);
        check("R9", {31'd0, flag_cy}, 32'd1);
        // enable low: flags hold (R10)
        apply(4'h0, 32'h1, 32'h1, 1'b0, 32'h2);
        check("R10", {29'd0, flag_z, flag_s, flag_cy}, 32'b101);
        // logic op with enable high: flags hold (R10)
        apply(4'h2, 32'h0, 32'h0, 1'b1, 32'h0);
        // reserved code with enable high: flags hold (R7)
        apply(4'hE, 32'h8000_0000, 32'h8000_0000, 1'b1, 32'h0);
        check("R7", {29'd0, flag_z, flag_s, flag_cy}, 32'b101);
        // negative add result sets sign (R8)
        apply(4'h0, 32'h8000_0000, 32'h1, 1'b1, 32'h8000_0001);
        check("R8", {29'd0, flag_z, flag_s, flag_cy}, 32'b010);
        // subtract equal operands: z=1 cy=1 (R9)
        apply(4'h1, 32'h55, 32'h55, 1'b1, 32'h0);
        check("R9", {29'd0, flag_z, flag_s, flag_cy}, 32'b101);

        // asynchronous reset between edges (R11)
        @(negedge clk); #1;
        rst_n = 1'b0;
        #1;
        ez = 0; es = 0; ecy = 0;
        check_flags("R11");
        @(negedge clk) rst_n = 1'b1;
        apply(4'h1, 32'h0, 32'h1, 1'b1, 32'hFFFF_FFFF);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
        $finish;
    end
endmodule